// File: doc/BRIEF.md
# Vector Lane Move and Replicate Unit

This unit is the element-movement slice of a 256-bit vector execution pipe. The low 128 bits of every vector also serve as a short-vector view. Each issued operation names one of eight moves through an opcode, an element size and a 128/256 width bit. The eight moves are:

- put a 64-bit scalar into one lane;
- read one lane out as a signed or unsigned 64-bit scalar;
- spread a scalar over every lane;
- spread lane 0, or an indexed lane, of a vector;
- copy lane 0 of one vector into an indexed lane of another;
- take an indexed lane down to lane 0 with all higher bits cleared.

Results appear on registered outputs one clock after the issue strobe. Register files, decode and memory access belong to the surrounding pipe. The unit sees only operand values and returns result values.

An operation that the width, size and index do not allow is reported through a flag. It leaves both result registers untouched.

Top module: `lanemv_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_illegal`, `out_vec` and `out_scl` are cleared to zero.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and results of that issue are present in the same cycle.
- R3: Op 0 (scalar insert, sizes 0..3) returns `in_vec_b` with the lane at `in_idx` replaced by the low 8<<size bits of `in_scl`. Size 0 is byte, 1 halfword, 2 word, 3 doubleword and 4 quadword. Lane k occupies bits starting at k·(8<<size).
- R4: Op 1 (signed extract) and op 2 (unsigned extract), sizes 0..3, place the lane `in_idx` of `in_vec_a` on `out_scl`. Op 1 sign-extends the lane to 64 bits and op 2 zero-extends it.
- R5: Op 3 (scalar broadcast, sizes 0..3) writes the low 8<<size bits of `in_scl` into every lane of the active width.
- R6: Op 4 (lane-0 broadcast) is legal only with `in_wide`=1 and sizes 0..4. It copies lane 0 of `in_vec_a` into every lane of all 256 bits.
- R7: Op 5 (indexed broadcast) is legal only with `in_wide`=0 and sizes 0..3. It copies lane `in_idx` of `in_vec_a` into every lane of the low 128 bits.
- R8: Op 6 (lane-0 insert) is legal only with `in_wide`=1 and sizes 2 or 3. It returns `in_vec_b` with lane `in_idx` replaced by lane 0 of `in_vec_a`.
- R9: Op 7 (pick) is legal only with `in_wide`=1 and sizes 2 or 3. It puts lane `in_idx` of `in_vec_a` into lane 0 and clears every higher bit.
- R10: With `in_wide`=0, bits 255:128 of a legal vector result are zero.
- R11: An opcode/size/width combination outside R3..R9 sets `out_illegal` together with `out_valid`, and `out_vec` and `out_scl` keep their values.
- R12: For indexed ops (0, 1, 2, 5, 6, 7) an `in_idx` not below the lane count (16 or 32 bytes divided by 1<<size) is illegal as in R11.
- R13: Extract ops leave `out_vec` unchanged, and vector ops leave `out_scl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 3 | Operation code (0..7) |
| in_size | input | 3 | Element size code (0..4) |
| in_wide | input | 1 | 1: 256-bit operation, 0: 128-bit |
| in_idx | input | 5 | Lane index immediate |
| in_scl | input | 64 | Scalar operand |
| in_vec_a | input | 256 | Source vector |
| in_vec_b | input | 256 | Destination vector prior contents |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Issue was an unsupported combination |
| out_scl | output | 64 | Registered scalar result |
| out_vec | output | 256 | Registered vector result |

## Verification
An issue can be rejected as illegal in the same cycle that a second result register is expected to hold. The illegal flag and the hold of both result registers therefore fall in one cycle. The bench provokes this by placing rejected combinations directly after legal vector and scalar writes in its vector table. Examples are pick with a too-large index, quadword scalar broadcast, and lane-0 broadcast in 128-bit mode. A reference model predicts the flag and the unchanged values, and the bench compares them at the next falling edge. The same pairing is tested with extracts issued right after vector writes, where `out_vec` must stay as it was while `out_scl` changes.

// File: rtl/lanemv_pkg.sv
// Package: shared opcode and element-size encodings for the lane move unit.
package lanemv_pkg;
    typedef enum logic [2:0] {
        OP_INS_SCL  = 3'd0,
        OP_EXT_SGN  = 3'd1,
        OP_EXT_UNS  = 3'd2,
        OP_BC_SCL   = 3'd3,
        OP_BC_LANE0 = 3'd4,
        OP_BC_IDX   = 3'd5,
        OP_INS_L0   = 3'd6,
        OP_PICK     = 3'd7
    } lanemv_op_e;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd0,
        SZ_HALF = 3'd1,
        SZ_WORD = 3'd2,
        SZ_DBL  = 3'd3,
        SZ_QUAD = 3'd4
    } lanemv_size_e;
endpackage

// File: rtl/lanemv_decode.sv
// Module: lanemv_decode
// Decides whether an issue is legal and which result register it writes.
// Assumes the index is counted in lanes of the selected element size.
module lanemv_decode
    import lanemv_pkg::*;
#(
    parameter int VEC_W = 256,
    parameter int IDX_W = 5
) (
    input  lanemv_op_e       op,
    input  lanemv_size_e     size,
    input  logic             wide,
    input  logic [IDX_W-1:0] idx,
    output logic             legal,
    output logic             wr_vec,
    output logic             wr_scl
);
    localparam int BYTES_W = VEC_W / 8;
    localparam int BYTES_N = BYTES_W / 2;
    localparam int CNT_W   = $clog2(BYTES_W) + 1;

    logic [CNT_W-1:0] lanes;
    logic             idx_ok;
    logic             is_ext;

    // Lane count for the active width and size, and index range test.
    always_comb begin
        lanes  = (wide ? CNT_W'(BYTES_W) : CNT_W'(BYTES_N)) >> size;
        idx_ok = CNT_W'(idx) < lanes;
        is_ext = (op == OP_EXT_SGN) || (op == OP_EXT_UNS);
    end

    // Legality table per operation.
    always_comb begin
        unique case (op)
            OP_INS_SCL, OP_EXT_SGN, OP_EXT_UNS:
                legal = (size <= SZ_DBL) && idx_ok;
            OP_BC_SCL:
                legal = (size <= SZ_DBL);
            OP_BC_LANE0:
                legal = wide && (size <= SZ_QUAD);
            OP_BC_IDX:
                legal = !wide && (size <= SZ_DBL) && idx_ok;
            OP_INS_L0, OP_PICK:
                legal = wide && ((size == SZ_WORD) || (size == SZ_DBL)) && idx_ok;
            default:
                legal = 1'b0;
        endcase
        wr_scl = legal && is_ext;
        wr_vec = legal && !is_ext;
    end
endmodule

// File: rtl/lanemv_datapath.sv
// Module: lanemv_datapath
// Combinational lane select, insert, replicate and extend network.
// Assumes element sizes are powers of two from 8 bits up to VEC_W/2.
module lanemv_datapath
    import lanemv_pkg::*;
#(
    parameter int VEC_W = 256,
    parameter int SCL_W = 64,
    parameter int IDX_W = 5
) (
    input  lanemv_op_e       op,
    input  lanemv_size_e     size,
    input  logic             wide,
    input  logic [IDX_W-1:0] idx,
    input  logic [SCL_W-1:0] scl,
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    output logic [VEC_W-1:0] nxt_vec,
    output logic [SCL_W-1:0] nxt_scl
);
    localparam int HALF_W = VEC_W / 2;
    localparam int EW     = $clog2(HALF_W);

    logic [7:0]        ebits;
    logic [HALF_W-1:0] emask;
    logic [HALF_W-1:0] elem_i;
    logic [HALF_W-1:0] elem_0;
    logic [HALF_W-1:0] elem_s;
    logic              sgn;
    int                sh;

    // Replicates the low eb bits of e across the whole vector.
    function automatic logic [VEC_W-1:0] repl(input logic [HALF_W-1:0] e,
                                              input logic [7:0] eb);
        logic [VEC_W-1:0] r;
        for (int i = 0; i < VEC_W; i++) begin
            r[i] = e[EW'(i & (int'(eb) - 1))];
        end
        return r;
    endfunction

    // Overwrites the lane at bit offset s of dest with val under mask m.
    function automatic logic [VEC_W-1:0] place(input logic [VEC_W-1:0] dest,
                                               input logic [HALF_W-1:0] val,
                                               input logic [HALF_W-1:0] m,
                                               input int s);
        logic [VEC_W-1:0] wm;
        wm = VEC_W'(m) << s;
        return (dest & ~wm) | (VEC_W'(val) << s);
    endfunction

    // Element width, mask, offset and the three candidate element sources.
    always_comb begin
        ebits  = 8'd8 << size;
        emask  = (HALF_W'(1) << ebits) - HALF_W'(1);
        sh     = int'(idx) * int'(ebits);
        elem_i = HALF_W'(vec_a >> sh) & emask;
        elem_0 = vec_a[HALF_W-1:0] & emask;
        elem_s = HALF_W'(scl) & emask;
        sgn    = (op == OP_EXT_SGN) && elem_i[EW'(ebits - 8'd1)];
    end

    // Result selection per operation, with upper half cleared in narrow mode.
    always_comb begin
        nxt_vec = '0;
        nxt_scl = elem_i[SCL_W-1:0] | ({SCL_W{sgn}} & ~emask[SCL_W-1:0]);
        unique case (op)
            OP_INS_SCL:  nxt_vec = place(vec_b, elem_s, emask, sh);
            OP_BC_SCL:   nxt_vec = repl(elem_s, ebits);
            OP_BC_LANE0: nxt_vec = repl(elem_0, ebits);
            OP_BC_IDX:   nxt_vec = repl(elem_i, ebits);
            OP_INS_L0:   nxt_vec = place(vec_b, elem_0, emask, sh);
            OP_PICK:     nxt_vec = VEC_W'(elem_i);
            default:     nxt_vec = '0;
        endcase
        if (!wide) begin
            nxt_vec[VEC_W-1:HALF_W] = '0;
        end
    end
endmodule

// File: rtl/lanemv_unit.sv
// Module: lanemv_unit (top)
// Registers decode and datapath results one cycle after issue.
// Assumes synchronous active-low reset; illegal issues hold both results.
module lanemv_unit
    import lanemv_pkg::*;
#(
    parameter int VEC_W = 256,
    parameter int SCL_W = 64,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [2:0]       in_size,
    input  logic             in_wide,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [SCL_W-1:0] in_scl,
    input  logic [VEC_W-1:0] in_vec_a,
    input  logic [VEC_W-1:0] in_vec_b,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [SCL_W-1:0] out_scl,
    output logic [VEC_W-1:0] out_vec
);
    lanemv_op_e       op;
    lanemv_size_e     size;
    logic             legal;
    logic             wr_vec;
    logic             wr_scl;
    logic [VEC_W-1:0] nxt_vec;
    logic [SCL_W-1:0] nxt_scl;

    // Typed views of the raw opcode and size ports.
    always_comb begin
        op   = lanemv_op_e'(in_op);
        size = lanemv_size_e'(in_size);
    end

    lanemv_decode #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_dec (
        .op(op), .size(size), .wide(in_wide), .idx(in_idx),
        .legal(legal), .wr_vec(wr_vec), .wr_scl(wr_scl)
    );

    lanemv_datapath #(.VEC_W(VEC_W), .SCL_W(SCL_W), .IDX_W(IDX_W)) u_dp (
        .op(op), .size(size), .wide(in_wide), .idx(in_idx), .scl(in_scl),
        .vec_a(in_vec_a), .vec_b(in_vec_b),
        .nxt_vec(nxt_vec), .nxt_scl(nxt_scl)
    );

    // Result and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_scl     <= '0;
            out_vec     <= '0;
        end else begin
            out_valid   <= in_valid;
            out_illegal <= in_valid && !legal;
            if (in_valid && wr_vec) out_vec <= nxt_vec;
            if (in_valid && wr_scl) out_scl <= nxt_scl;
        end
    end
endmodule

// File: rtl/lanemv_unit_checker.sv
// Module: lanemv_unit_checker
// Temporal properties of the lane move unit, bound to every instance.
module lanemv_unit_checker
    import lanemv_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [2:0]   in_op,
    input logic         in_wide,
    input logic         out_valid,
    input logic         out_illegal,
    input logic [255:0] out_vec
);
    logic is_ext;

    // Extract opcode detector.
    always_comb is_ext = (in_op == OP_EXT_SGN) || (in_op == OP_EXT_UNS);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r11_hold_vec: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && out_valid && out_illegal |-> $stable(out_vec));
    a_r13_ext_keeps_vec: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_ext |=> $stable(out_vec));
    a_r10_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_wide && !is_ext |=> out_illegal || (out_vec[255:128] == '0));
    a_r9_pick_clear: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_op == OP_PICK) |=> out_illegal || (out_vec[255:64] == '0));
endmodule

bind lanemv_unit lanemv_unit_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_wide(in_wide), .out_valid(out_valid), .out_illegal(out_illegal),
    .out_vec(out_vec)
);

// File: tb/lanemv_unit_bench.sv
// Bench: vector table walk with a reference model, then directed cases.
module lanemv_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   in_op = '0;
    logic [2:0]   in_size = '0;
    logic         in_wide = 1'b0;
    logic [4:0]   in_idx = '0;
    logic [63:0]  in_scl = '0;
    logic [255:0] in_vec_a = '0;
    logic [255:0] in_vec_b = '0;
    logic         out_valid;
    logic         out_illegal;
    logic [63:0]  out_scl;
    logic [255:0] out_vec;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [255:0] exp_vec = '0;
    logic [63:0]  exp_scl = '0;
    logic         exp_ill;

    always #2 clk = ~clk;

    lanemv_unit u_lanemv_unit (.*);

    // Table entry: {expected illegal, op, size, wide, idx}
    localparam int NV = 23;
    localparam logic [12:0] TBL [NV] = '{
        {1'b0, 3'd0, 3'd0, 1'b0, 5'd5},
        {1'b0, 3'd0, 3'd1, 1'b1, 5'd12},
        {1'b0, 3'd0, 3'd3, 1'b0, 5'd1},
        {1'b1, 3'd0, 3'd0, 1'b0, 5'd16},
        {1'b0, 3'd1, 3'd0, 1'b1, 5'd31},
        {1'b0, 3'd2, 3'd1, 1'b0, 5'd7},
        {1'b0, 3'd1, 3'd2, 1'b1, 5'd3},
        {1'b0, 3'd2, 3'd3, 1'b1, 5'd3},
        {1'b0, 3'd3, 3'd0, 1'b0, 5'd0},
        {1'b0, 3'd3, 3'd2, 1'b1, 5'd0},
        {1'b1, 3'd3, 3'd4, 1'b0, 5'd0},
        {1'b0, 3'd4, 3'd4, 1'b1, 5'd0},
        {1'b0, 3'd4, 3'd1, 1'b1, 5'd0},
        {1'b1, 3'd4, 3'd0, 1'b0, 5'd0},
        {1'b0, 3'd5, 3'd1, 1'b0, 5'd5},
        {1'b1, 3'd5, 3'd3, 1'b1, 5'd1},
        {1'b0, 3'd6, 3'd2, 1'b1, 5'd7},
        {1'b0, 3'd6, 3'd3, 1'b1, 5'd3},
        {1'b1, 3'd6, 3'd0, 1'b1, 5'd0},
        {1'b0, 3'd7, 3'd2, 1'b1, 5'd6},
        {1'b0, 3'd7, 3'd3, 1'b1, 5'd2},
        {1'b1, 3'd7, 3'd3, 1'b1, 5'd4},
        {1'b0, 3'd1, 3'd3, 1'b0, 5'd1}
    };

    // Reference model written from the requirements, byte by byte.
    function automatic void model(input logic [2:0] op, input logic [2:0] sz,
                                  input logic wide, input logic [4:0] idx,
                                  input logic [63:0] s, input logic [255:0] a,
                                  input logic [255:0] b);
        int eb = 1 << sz;
        int nb = wide ? 32 : 16;
        int lanes = nb / eb;
        int base = int'(idx) * eb;
        bit ok;
        logic [255:0] v = '0;
        logic [63:0] x = '0;
        case (op)
            3'd0, 3'd1, 3'd2: ok = (sz <= 3) && (int'(idx) < lanes);
            3'd3: ok = (sz <= 3);
            3'd4: ok = wide && (sz <= 4);
            3'd5: ok = !wide && (sz <= 3) && (int'(idx) < lanes);
            default: ok = wide && (sz == 2 || sz == 3) && (int'(idx) < lanes);
        endcase
        exp_ill = !ok;
        if (!ok) return;
        if (op == 3'd1 || op == 3'd2) begin
            for (int k = 0; k < 8; k++) begin
                if (k < eb) x[8*k +: 8] = a[8*(base+k) +: 8];
                else x[8*k +: 8] = (op == 3'd1 && a[8*(base+eb)-1]) ? 8'hFF : 8'h00;
            end
            exp_scl = x;
            return;
        end
        case (op)
            3'd0: begin
                v = b;
                for (int k = 0; k < eb; k++) v[8*(base+k) +: 8] = s[8*k +: 8];
            end
            3'd3: for (int j = 0; j < nb; j++) v[8*j +: 8] = s[8*(j % eb) +: 8];
            3'd4: for (int j = 0; j < 32; j++) v[8*j +: 8] = a[8*(j % eb) +: 8];
            3'd5: for (int j = 0; j < 16; j++) v[8*j +: 8] = a[8*(base + j % eb) +: 8];
            3'd6: begin
                v = b;
                for (int k = 0; k < eb; k++) v[8*(base+k) +: 8] = a[8*k +: 8];
            end
            default: for (int k = 0; k < eb; k++) v[8*k +: 8] = a[8*(base+k) +: 8];
        endcase
        if (!wide) v[255:128] = '0;
        exp_vec = v;
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1, 3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issues one op at a falling edge and waits to the next falling edge.
    task automatic issue(input logic [2:0] op, input logic [2:0] sz, input logic wide,
                         input logic [4:0] idx, input logic [63:0] s);
        in_op = op; in_size = sz; in_wide = wide; in_idx = idx; in_scl = s;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model(op, sz, wide, idx, s, in_vec_a, in_vec_b);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            in_vec_a[8*i +: 8] = 8'(i * 17);
            in_vec_b[8*i +: 8] = 8'hC0 ^ 8'(i);
        end
        repeat (3) @(negedge clk);
        chk("R1 valid", 256'(out_valid), 256'(0));
        chk("R1 vec", out_vec, '0);
        chk("R1 scl", 256'(out_scl), '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [63:0] s = 64'hF1E2_D3C4_B5A6_9788 ^ (64'(i) * 64'h0101_0101_0101_0101);
            issue(TBL[i][11:9], TBL[i][8:6], TBL[i][5], TBL[i][4:0], s);
            chk("R2 valid", 256'(out_valid), 256'(1));
            chk(TBL[i][12] ? "R11 flag" : "R11 flag clear", 256'(out_illegal), 256'(TBL[i][12]));
            chk("R11 model", 256'(exp_ill), 256'(TBL[i][12]));
            chk((TBL[i][11:9] == 3'd1 || TBL[i][11:9] == 3'd2) ? "R13 vec kept" :
                (TBL[i][5] ? tag_of(TBL[i][11:9]) : {tag_of(TBL[i][11:9]), "/R10"}),
                out_vec, exp_vec);
            chk((TBL[i][11:9] == 3'd1 || TBL[i][11:9] == 3'd2) ? tag_of(TBL[i][11:9]) : "R13 scl kept",
                256'(out_scl), 256'(exp_scl));
        end

        // Hand-computed extract values.
        issue(3'd1, 3'd0, 1'b0, 5'd15, '0);
        chk("R4 signed byte", 256'(out_scl), 256'(64'hFFFF_FFFF_FFFF_FFFF));
        issue(3'd2, 3'd0, 1'b0, 5'd15, '0);
        chk("R4 unsigned byte", 256'(out_scl), 256'(64'h0000_0000_0000_00FF));
        issue(3'd1, 3'd1, 1'b0, 5'd1, '0);
        chk("R4 signed positive half", 256'(out_scl), 256'(64'h3322));

        // Index range corner: last legal and first illegal.
        issue(3'd0, 3'd0, 1'b1, 5'd31, 64'h5A);
        chk("R12 last lane legal", 256'(out_illegal), 256'(0));
        chk("R3 top byte", 256'(out_vec[255:248]), 256'(8'h5A));
        issue(3'd7, 3'd2, 1'b1, 5'd8, '0);
        chk("R12 index past end", 256'(out_illegal), 256'(1));
        chk("R11 vec held", out_vec, exp_vec);

        // Idle cycle drops the strobe and holds results.
        @(negedge clk);
        chk("R2 idle", 256'(out_valid), 256'(0));
        chk("R2 hold", out_vec, exp_vec);

        // Mid-run reset.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 vec after reset", out_vec, '0);
        chk("R1 illegal after reset", 256'(out_illegal), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule